// File: doc/BRIEF.md
# DMA Region Bound Checker

This block stores the lower and upper bound of a single memory-protection window for a DMA engine, and tells the engine whether the address of the current transfer falls inside that window. Both bounds are 32-bit registers on a small register bus. Any access may read them, but only a write marked as privileged can change them. A write without privilege is dropped without any error.

The check is purely combinational. It takes the transfer address and a 2-bit transfer-size code and compares them against normalised bounds. The lower bound is aligned down to a 4-byte word. The upper bound is extended to the last byte of its word, or to the last byte of its 8-byte doubleword when the transfer is 64 bits wide. Both ends of the window are inclusive. When the normalised upper bound lies below the normalised lower bound, the window wraps past the top of the address space: it covers the span from the lower bound up to all-ones and the span from zero up to the upper bound.

The decision passes through two named spans. LINEAR means lower bound <= upper bound. WRAP means upper bound < lower bound. The span is chosen again in every cycle from the stored values and the transfer size. No other sequencing exists.

Top module: `dma_region_guard`

## Requirements
- R1: After reset both bound registers read as zero, so with a 32-bit transfer the window covers addresses 0x0 to 0x3 and excludes 0x4.
- R2: A privileged write (bus_sel=1, bus_wr=1, bus_priv=1) to offset 0x1C0 stores the lower bound, and one to offset 0x1C4 stores the upper bound. The new value takes effect at the clock edge. A read (bus_sel=1, bus_wr=0) returns the raw stored value on bus_rdata, without normalisation.
- R3: A write with bus_priv=0 leaves both registers unchanged, both as read back and in the window decision.
- R4: The effective lower bound is the stored value with bits [1:0] cleared, so a stored 0x103 admits 0x100 and excludes 0xFF.
- R5: For size codes 2'b00 (8-bit), 2'b01 (16-bit) and 2'b10 (32-bit), the effective upper bound is the stored value with bits [1:0] set, so a stored 0x200 admits 0x203 and excludes 0x204.
- R6: For size code 2'b11 (64-bit), the effective upper bound is the stored value with bits [2:0] set, so a stored 0x200 admits 0x207 and excludes 0x208. A 32-bit transfer to 0x207 is outside.
- R7: In the LINEAR span, in_region is 1 exactly when lower <= xfer_addr <= upper, with both ends included.
- R8: In the WRAP span, in_region is 1 exactly when xfer_addr >= lower or xfer_addr <= upper. Because the upper bound depends on the size code, the same stored pair can be WRAP for 32-bit transfers and LINEAR for 64-bit transfers.
- R9: A read of any other offset returns zero, and a write to any other offset changes neither register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Register bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_priv | input | 1 | Access is privileged |
| bus_addr | input | 12 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| xfer_addr | input | 32 | Byte address of the DMA transfer under test |
| xfer_size | input | 2 | Transfer size code: 00=8, 01=16, 10=32, 11=64 bits |
| in_region | output | 1 | Transfer address lies inside the window |

## Verification
A privileged bound write and a window decision can happen in the same cycle. The decision must use the old bound up to the clock edge and the new bound straight after it. The bench provokes this by driving a write to the lower bound and a transfer address in the same cycle. The address is chosen so that it lies inside the wrapped window before the write and outside it after the write. The bench samples in_region once before the edge, expecting the old answer, and once after it, expecting the new answer.

// File: rtl/dmp_pkg.sv
package dmp_pkg;

    typedef enum logic [1:0] {
        XFER_8  = 2'b00,
        XFER_16 = 2'b01,
        XFER_32 = 2'b10,
        XFER_64 = 2'b11
    } xfer_size_e;

    typedef enum logic {
        SPAN_LINEAR = 1'b0,
        SPAN_WRAP   = 1'b1
    } span_e;

    localparam int NUM_BOUNDS = 2;
    localparam int IDX_LOWER  = 0;
    localparam int IDX_UPPER  = 1;

endpackage

// File: rtl/dmp_bound_regs.sv
module dmp_bound_regs #(
    parameter int ADDR_W    = 32,
    parameter int OFS_W     = 12,
    parameter int LOWER_OFS = 'h1C0,
    parameter int UPPER_OFS = 'h1C4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic              bus_priv,
    input  logic [OFS_W-1:0]  bus_addr,
    input  logic [ADDR_W-1:0] bus_wdata,
    output logic [ADDR_W-1:0] bus_rdata,
    output logic [ADDR_W-1:0] lower_q,
    output logic [ADDR_W-1:0] upper_q
);
    import dmp_pkg::*;

    localparam logic [OFS_W-1:0] OFS_TABLE [NUM_BOUNDS] = '{
        OFS_W'(LOWER_OFS), OFS_W'(UPPER_OFS)
    };

    logic [ADDR_W-1:0] bank_q [NUM_BOUNDS];
    logic [NUM_BOUNDS-1:0] hit_ofs;
    logic wr_ok;

    assign wr_ok = bus_sel && bus_wr && bus_priv;

    for (genvar g = 0; g < NUM_BOUNDS; g++) begin : g_bank
        assign hit_ofs[g] = (bus_addr == OFS_TABLE[g]);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                bank_q[g] <= '0;
            end else if (wr_ok && hit_ofs[g]) begin
                bank_q[g] <= bus_wdata;
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_wr) begin
            for (int i = 0; i < NUM_BOUNDS; i++) begin
                if (hit_ofs[i]) bus_rdata = bank_q[i];
            end
        end
    end

    assign lower_q = bank_q[IDX_LOWER];
    assign upper_q = bank_q[IDX_UPPER];

    AST_UNPRIV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && !bus_priv) |=> ($stable(lower_q) && $stable(upper_q))); // R3

    AST_LOWER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_priv && bus_addr == OFS_W'(LOWER_OFS))
        |=> (lower_q == $past(bus_wdata))); // R2

    AST_UPPER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_priv && bus_addr == OFS_W'(UPPER_OFS))
        |=> (upper_q == $past(bus_wdata))); // R2

    AST_FOREIGN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr != OFS_W'(LOWER_OFS) && bus_addr != OFS_W'(UPPER_OFS))
        |=> ($stable(lower_q) && $stable(upper_q))); // R9

endmodule

// File: rtl/dmp_bound_norm.sv
module dmp_bound_norm #(
    parameter int ADDR_W    = 32,
    parameter int WORD_LSB  = 2,
    parameter int DWORD_LSB = 3
) (
    input  logic [ADDR_W-1:0]      lower_raw,
    input  logic [ADDR_W-1:0]      upper_raw,
    input  dmp_pkg::xfer_size_e    size,
    output logic [ADDR_W-1:0]      lower_eff,
    output logic [ADDR_W-1:0]      upper_eff
);
    import dmp_pkg::*;

    localparam logic [ADDR_W-1:0] WORD_MASK  = ADDR_W'((64'd1 << WORD_LSB) - 64'd1);
    localparam logic [ADDR_W-1:0] DWORD_MASK = ADDR_W'((64'd1 << DWORD_LSB) - 64'd1);

    assign lower_eff = lower_raw & ~WORD_MASK;

    always_comb begin
        unique case (size)
            XFER_64: upper_eff = upper_raw | DWORD_MASK;
            default: upper_eff = upper_raw | WORD_MASK;
        endcase
    end

endmodule

// File: rtl/dmp_span_cmp.sv
module dmp_span_cmp #(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] lower_eff,
    input  logic [ADDR_W-1:0] upper_eff,
    input  logic [ADDR_W-1:0] addr,
    output dmp_pkg::span_e    span,
    output logic              hit
);
    import dmp_pkg::*;

    logic above_lower;
    logic below_upper;

    assign above_lower = (addr >= lower_eff);
    assign below_upper = (addr <= upper_eff);
    assign span        = (upper_eff < lower_eff) ? SPAN_WRAP : SPAN_LINEAR;

    always_comb begin
        unique case (span)
            SPAN_LINEAR: hit = above_lower && below_upper;
            SPAN_WRAP:   hit = above_lower || below_upper;
            default:     hit = 1'b0;
        endcase
    end

endmodule

// File: rtl/dma_region_guard.sv
module dma_region_guard #(
    parameter int ADDR_W    = 32,
    parameter int OFS_W     = 12,
    parameter int LOWER_OFS = 'h1C0,
    parameter int UPPER_OFS = 'h1C4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic              bus_priv,
    input  logic [OFS_W-1:0]  bus_addr,
    input  logic [ADDR_W-1:0] bus_wdata,
    output logic [ADDR_W-1:0] bus_rdata,
    input  logic [ADDR_W-1:0] xfer_addr,
    input  logic [1:0]        xfer_size,
    output logic              in_region
);
    import dmp_pkg::*;

    logic [ADDR_W-1:0] lower_q;
    logic [ADDR_W-1:0] upper_q;
    logic [ADDR_W-1:0] lower_eff;
    logic [ADDR_W-1:0] upper_eff;
    xfer_size_e        size_e;
    span_e             span;

    assign size_e = xfer_size_e'(xfer_size);

    dmp_bound_regs #(
        .ADDR_W    (ADDR_W),
        .OFS_W     (OFS_W),
        .LOWER_OFS (LOWER_OFS),
        .UPPER_OFS (UPPER_OFS)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_priv  (bus_priv),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .lower_q   (lower_q),
        .upper_q   (upper_q)
    );

    dmp_bound_norm #(
        .ADDR_W    (ADDR_W),
        .WORD_LSB  (2),
        .DWORD_LSB (3)
    ) u_norm (
        .lower_raw (lower_q),
        .upper_raw (upper_q),
        .size      (size_e),
        .lower_eff (lower_eff),
        .upper_eff (upper_eff)
    );

    dmp_span_cmp #(
        .ADDR_W (ADDR_W)
    ) u_cmp (
        .lower_eff (lower_eff),
        .upper_eff (upper_eff),
        .addr      (xfer_addr),
        .span      (span),
        .hit       (in_region)
    );

    AST_LOWER_WORD_IN: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_addr == {lower_q[ADDR_W-1:2], 2'b00}) |-> in_region); // R4

    AST_UPPER_WORD_IN: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_size != 2'b11 && xfer_addr == {upper_q[ADDR_W-1:2], 2'b11}) |-> in_region); // R5

    AST_UPPER_DWORD_IN: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_size == 2'b11 && xfer_addr == {upper_q[ADDR_W-1:3], 3'b111}) |-> in_region); // R6

    AST_LINEAR_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
        (span == SPAN_LINEAR && (xfer_addr < lower_eff || xfer_addr > upper_eff)) |-> !in_region); // R7

    AST_WRAP_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (span == SPAN_WRAP && xfer_addr < lower_eff && xfer_addr > upper_eff) |-> !in_region); // R8

endmodule

// File: tb/dma_region_guard_tb.sv
module dma_region_guard_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_priv = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] xfer_addr = '0;
    logic [1:0]  xfer_size = 2'b10;
    logic        in_region;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    localparam logic [11:0] OFS_LO = 12'h1C0;
    localparam logic [11:0] OFS_HI = 12'h1C4;
    localparam logic [1:0]  SZ_B = 2'b00, SZ_H = 2'b01, SZ_W = 2'b10, SZ_D = 2'b11;

    typedef struct {
        bit          is_read;
        logic [31:0] exp;
        string       req;
    } sb_item_t;

    sb_item_t sb_q[$];

    always #4 clk = ~clk;

    dma_region_guard u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_priv  (bus_priv),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .xfer_addr (xfer_addr),
        .xfer_size (xfer_size),
        .in_region (in_region)
    );

    task automatic judge(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    // Monitor: samples 2 ns after each rising edge and compares against the oldest queued item
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb_q.size() > 0) begin
                sb_item_t it;
                it = sb_q.pop_front();
                if (it.is_read) judge(it.req, bus_rdata, it.exp);
                else            judge(it.req, {31'd0, in_region}, it.exp);
            end
        end
    end

    task automatic reg_write(input logic [11:0] ofs, input logic [31:0] val, input logic priv);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_priv = priv; bus_addr = ofs; bus_wdata = val;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_priv = 1'b0;
    endtask

    task automatic push_read(input logic [11:0] ofs, input logic [31:0] exp, input string req);
        sb_item_t it;
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = ofs;
        it.is_read = 1'b1; it.exp = exp; it.req = req;
        sb_q.push_back(it);
    endtask

    task automatic push_hit(input logic [31:0] a, input logic [1:0] sz, input bit exp, input string req);
        sb_item_t it;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
        xfer_addr = a; xfer_size = sz;
        it.is_read = 1'b0; it.exp = {31'd0, exp}; it.req = req;
        sb_q.push_back(it);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset values and default window
        push_read(OFS_LO, 32'h0, "R1 lower reset");
        push_read(OFS_HI, 32'h0, "R1 upper reset");
        push_hit(32'h0, SZ_W, 1'b1, "R1 addr 0");
        push_hit(32'h3, SZ_W, 1'b1, "R1 addr 3");
        push_hit(32'h4, SZ_W, 1'b0, "R1 addr 4");
        push_hit(32'h7, SZ_D, 1'b1, "R6 reset dword 7");
        push_hit(32'h8, SZ_D, 1'b0, "R6 reset dword 8");

        // R3: unprivileged write dropped
        reg_write(OFS_LO, 32'h500, 1'b0);
        push_read(OFS_LO, 32'h0, "R3 lower unchanged");
        push_hit(32'h500, SZ_W, 1'b0, "R3 window unchanged");

        // R2: privileged writes, raw readback
        reg_write(OFS_LO, 32'h103, 1'b1);
        reg_write(OFS_HI, 32'h200, 1'b1);
        push_read(OFS_LO, 32'h103, "R2 lower raw");
        push_read(OFS_HI, 32'h200, "R2 upper raw");

        // R4..R7: normalisation and linear span
        push_hit(32'h100, SZ_W, 1'b1, "R4 lower aligned");
        push_hit(32'hFF,  SZ_W, 1'b0, "R4 below lower");
        push_hit(32'h203, SZ_B, 1'b1, "R5 upper byte");
        push_hit(32'h204, SZ_H, 1'b0, "R5 past upper");
        push_hit(32'h207, SZ_D, 1'b1, "R6 dword upper");
        push_hit(32'h208, SZ_D, 1'b0, "R6 past dword");
        push_hit(32'h207, SZ_W, 1'b0, "R6 word size at 207");
        push_hit(32'h180, SZ_W, 1'b1, "R7 interior");

        reg_write(OFS_HI, 32'h50, 1'b0);
        push_read(OFS_HI, 32'h200, "R3 upper unchanged");

        // R9: foreign offset
        reg_write(12'h1C8, 32'hDEAD_BEEF, 1'b1);
        push_read(12'h1C8, 32'h0, "R9 foreign read");
        push_read(OFS_LO, 32'h103, "R9 lower intact");
        push_read(OFS_HI, 32'h200, "R9 upper intact");

        // R8: wrap
        reg_write(OFS_LO, 32'hFFFF_FF00, 1'b1);
        reg_write(OFS_HI, 32'h0000_0010, 1'b1);
        push_hit(32'hFFFF_FFFF, SZ_W, 1'b1, "R8 top");
        push_hit(32'hFFFF_FF00, SZ_W, 1'b1, "R8 lower");
        push_hit(32'h0,         SZ_W, 1'b1, "R8 zero");
        push_hit(32'h13,        SZ_W, 1'b1, "R8 upper");
        push_hit(32'h14,        SZ_W, 1'b0, "R8 past upper");
        push_hit(32'h8000_0000, SZ_W, 1'b0, "R8 gap middle");
        push_hit(32'hFFFF_FEFF, SZ_W, 1'b0, "R8 below lower");

        // R8/R6: span depends on size
        reg_write(OFS_LO, 32'h104, 1'b1);
        reg_write(OFS_HI, 32'h100, 1'b1);
        push_hit(32'h104,   SZ_W, 1'b1, "R8 word wrap lower");
        push_hit(32'h103,   SZ_W, 1'b1, "R8 word wrap upper");
        push_hit(32'h50000, SZ_W, 1'b1, "R8 word wrap high");
        push_hit(32'h50000, SZ_D, 1'b0, "R8 dword linear high");
        push_hit(32'h105,   SZ_D, 1'b1, "R8 dword linear inside");
        push_hit(32'h108,   SZ_D, 1'b0, "R8 dword linear past");

        // R2: write and decision in the same cycle
        begin
            sb_item_t it;
            @(negedge clk);
            bus_sel = 1'b1; bus_wr = 1'b1; bus_priv = 1'b1;
            bus_addr = OFS_LO; bus_wdata = 32'h1000;
            xfer_addr = 32'h800; xfer_size = SZ_W;
            #1;
            judge("R2 old bound before edge", {31'd0, in_region}, 32'h1);
            it.is_read = 1'b0; it.exp = 32'h0; it.req = "R2 new bound after edge";
            sb_q.push_back(it);
            @(negedge clk);
            bus_sel = 1'b0; bus_wr = 1'b0; bus_priv = 1'b0;
        end

        while (sb_q.size() > 0) @(negedge clk);
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule